// File: doc/BRIEF.md
# Byte-Addressed Word Load/Store Unit

This unit moves operands between a byte-wide, single-port synchronous RAM and a file of 24-bit registers plus one 48-bit floating-point register. A word is three bytes held at consecutive addresses and a float is six. Multi-byte values are big-endian: the byte at the start address is the most significant. The unit also moves single bytes, which touch only the low byte of the accumulator register.

A request gives an operation, a start address and a register selector. The request is accepted on a rising edge only while the unit is idle. The unit then makes one RAM access per cycle at rising addresses, and the address wraps at the end of memory. When the transfer is finished, the unit pulses `done` for one cycle. For loads, the register write happens in that same cycle. The register file and the RAM sit outside the block. The unit reads the register file combinationally in the acceptance cycle and writes it through dedicated write ports.

The controller has four states: IDLE, ISSUE, DRAIN and FINISH. The transitions are:
- IDLE to ISSUE when a legal request is accepted.
- ISSUE to itself while accesses remain.
- ISSUE to DRAIN after the last read access.
- ISSUE to FINISH after the last write access.
- DRAIN to FINISH, unconditionally.
- FINISH to IDLE, unconditionally.

Top module: `wordmover_lsu`

## Requirements
- R1: While reset is held and directly after it, `busy`, `done`, `mem_en`, `rf_we` and `rf_fwe` are all 0.
- R2: `req_op` encodes 0 load word, 1 load float, 2 load byte, 4 store word, 5 store float, 6 store byte. Codes 3 and 7 are ignored, and so is a word operation whose `req_sel` is above 5. An ignored request leaves `busy` at 0 and produces no `done`.
- R3: A load word reads bytes m, m+1 and m+2 big-endian and writes them through `rf_we`/`rf_wsel`/`rf_wdata` into the register named by `req_sel`. The selector encoding is A=0, X=1, L=2, B=3, S=4, T=5.
- R4: A load float reads bytes m through m+5 big-endian and writes all 48 bits through `rf_fwe`/`rf_fwdata`. `rf_we` is not asserted.
- R5: A load byte writes register A (selector 0). Bits 7:0 take byte m and bits 23:8 keep the value A had at acceptance. `req_sel` is ignored.
- R6: A store word writes the selected register to m, m+1 and m+2, most significant byte first.
- R7: A store float writes the 48-bit `rf_fdata` to m through m+5, most significant byte first.
- R8: A store byte writes bits 7:0 of register A to address m and to no other address.
- R9: Exactly one RAM access happens per cycle, only while `busy`. Successive accesses use successive addresses, wrapping modulo 2^ADDR_W.
- R10: `done` is high for exactly one cycle, at the (N+1)-th rising edge after acceptance for a load and at the N-th for a store, where N is the byte count. `busy` falls on the edge after `done`.
- R11: A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Start byte address |
| req_sel | input | 3 | Register selector for word operations |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ADDR_W | RAM byte address |
| mem_wdata | output | BYTE_W | RAM write byte |
| mem_rdata | input | BYTE_W | RAM read byte, valid the cycle after the access |
| rf_rsel | output | 3 | Register read selector |
| rf_rdata | input | 3*BYTE_W | Register read data |
| rf_fdata | input | 6*BYTE_W | Float register read data |
| rf_we | output | 1 | Word register write enable |
| rf_wsel | output | 3 | Word register write selector |
| rf_wdata | output | 3*BYTE_W | Word register write data |
| rf_fwe | output | 1 | Float register write enable |
| rf_fwdata | output | 6*BYTE_W | Float register write data |

## Verification
If the byte counter is off by one or takes a wrong transition, the effect appears at the moment of completion. `done` arrives one cycle early or late, and the last byte of a load lands in the wrong position of the register write. A stale shift-register position, or a wrong acceptance snapshot, shows as wrong data on the write port in the `done` cycle. For stores it shows as wrong RAM bytes, which are visible as soon as `done` is sampled. A broken idle gate shows within one transfer, as an extra `done` with nothing expected or as a RAM byte changed at an address no legal request named.

// File: rtl/wlsu_pkg.sv
package wlsu_pkg;

    typedef enum logic [2:0] {
        OP_LDW  = 3'd0,
        OP_LDF  = 3'd1,
        OP_LDB  = 3'd2,
        OP_RSV3 = 3'd3,
        OP_STW  = 3'd4,
        OP_STF  = 3'd5,
        OP_STB  = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_FINISH
    } state_e;

    typedef enum logic [1:0] {
        SZ_BYTE,
        SZ_WORD,
        SZ_FLOAT
    } size_e;

    localparam logic [2:0] SEL_ACC = 3'd0;

    function automatic size_e op_size(op_e op);
        size_e s;
        unique case (op)
            OP_LDW, OP_STW: s = SZ_WORD;
            OP_LDF, OP_STF: s = SZ_FLOAT;
            default:        s = SZ_BYTE;
        endcase
        return s;
    endfunction

    function automatic logic op_is_store(op_e op);
        return (op == OP_STW) || (op == OP_STF) || (op == OP_STB);
    endfunction

    function automatic logic op_legal(op_e op);
        return (op != OP_RSV3) && (op != OP_RSV7);
    endfunction

endpackage

// File: rtl/wlsu_ctrl.sv
module wlsu_ctrl
    import wlsu_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             acc_store,
    input  logic [CNT_W-1:0] acc_len_m1,
    output logic             issue,
    output logic             store_phase,
    output logic             commit_load,
    output logic             busy_o,
    output logic             done_o
);

    state_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             store_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Remaining-access counter and direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            store_q <= 1'b0;
        end else if (accept) begin
            cnt_q   <= acc_len_m1;
            store_q <= acc_store;
        end else if (state_q == ST_ISSUE && cnt_q != '0) begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (cnt_q == '0) state_d = store_q ? ST_FINISH : ST_DRAIN;
            end
            ST_DRAIN: begin
                state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        issue       = 1'b0;
        commit_load = 1'b0;
        done_o      = 1'b0;
        busy_o      = 1'b1;
        unique case (state_q)
            ST_IDLE:   busy_o = 1'b0;
            ST_ISSUE:  issue = 1'b1;
            ST_DRAIN:  ;
            ST_FINISH: begin
                done_o      = 1'b1;
                commit_load = !store_q;
            end
            default:   busy_o = 1'b0;
        endcase
    end

    assign store_phase = store_q;

endmodule

// File: rtl/wlsu_addr_gen.sv
module wlsu_addr_gen #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= start_addr;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;   // wraps modulo 2^ADDR_W
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/wlsu_shift.sv
module wlsu_shift #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_en,
    input  logic [BYTE_W*NBYTES-1:0] load_val,
    input  logic                     shl_en,
    input  logic                     shin_en,
    input  logic [BYTE_W-1:0]        byte_in,
    output logic [BYTE_W-1:0]        byte_out,
    output logic [BYTE_W*NBYTES-1:0] value
);

    localparam int TOT_W = BYTE_W * NBYTES;

    logic [TOT_W-1:0]  sh_q;
    logic [BYTE_W-1:0] fill;

    assign fill = shin_en ? byte_in : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_en) begin
            sh_q <= load_val;
        end else if (shl_en || shin_en) begin
            sh_q <= {sh_q[TOT_W-BYTE_W-1:0], fill};
        end
    end

    assign byte_out = sh_q[TOT_W-1 -: BYTE_W];
    assign value    = sh_q;

endmodule

// File: rtl/wordmover_lsu.sv
module wordmover_lsu
    import wlsu_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int BYTE_W      = 8,
    parameter int WORD_BYTES  = 3,
    parameter int NUM_WREGS   = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic [2:0]                     req_op,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [2:0]                     req_sel,
    output logic                           busy,
    output logic                           done,
    output logic                           mem_en,
    output logic                           mem_we,
    output logic [ADDR_W-1:0]              mem_addr,
    output logic [BYTE_W-1:0]              mem_wdata,
    input  logic [BYTE_W-1:0]              mem_rdata,
    output logic [2:0]                     rf_rsel,
    input  logic [BYTE_W*WORD_BYTES-1:0]   rf_rdata,
    input  logic [2*BYTE_W*WORD_BYTES-1:0] rf_fdata,
    output logic                           rf_we,
    output logic [2:0]                     rf_wsel,
    output logic [BYTE_W*WORD_BYTES-1:0]   rf_wdata,
    output logic                           rf_fwe,
    output logic [2*BYTE_W*WORD_BYTES-1:0] rf_fwdata
);

    localparam int FLOAT_BYTES = 2 * WORD_BYTES;
    localparam int WORD_W      = BYTE_W * WORD_BYTES;
    localparam int FLT_W       = BYTE_W * FLOAT_BYTES;
    localparam int CNT_W       = $clog2(FLOAT_BYTES);

    op_e              op_in;
    size_e            size_in, size_q;
    logic             sel_ok, accept;
    logic [CNT_W-1:0] len_m1;
    logic [2:0]       sel_q;
    logic [WORD_W-1:0] hold_q;
    logic [FLT_W-1:0] load_val, sh_val;
    logic             issue, store_phase, commit_load;
    logic             rd_pend_q;

    // Request decode
    assign op_in   = op_e'(req_op);
    assign size_in = op_size(op_in);
    assign sel_ok  = (size_in != SZ_WORD) || (req_sel < 3'(NUM_WREGS));
    assign accept  = req_valid && !busy && op_legal(op_in) && sel_ok;
    assign rf_rsel = (size_in == SZ_BYTE) ? SEL_ACC : req_sel;

    always_comb begin
        unique case (size_in)
            SZ_WORD:  len_m1 = CNT_W'(WORD_BYTES - 1);
            SZ_FLOAT: len_m1 = CNT_W'(FLOAT_BYTES - 1);
            default:  len_m1 = '0;
        endcase
    end

    // Store image, left-aligned so the most significant byte leaves first
    always_comb begin
        load_val = '0;
        if (op_is_store(op_in)) begin
            unique case (size_in)
                SZ_WORD:  load_val = {rf_rdata, {(FLT_W-WORD_W){1'b0}}};
                SZ_FLOAT: load_val = rf_fdata;
                default:  load_val = {rf_rdata[BYTE_W-1:0], {(FLT_W-BYTE_W){1'b0}}};
            endcase
        end
    end

    // Request snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= SZ_BYTE;
            sel_q  <= SEL_ACC;
            hold_q <= '0;
        end else if (accept) begin
            size_q <= size_in;
            sel_q  <= (size_in == SZ_BYTE) ? SEL_ACC : req_sel;
            hold_q <= rf_rdata;
        end
    end

    // A read issued last cycle returns data this cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
        end else begin
            rd_pend_q <= mem_en && !mem_we;
        end
    end

    wlsu_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .acc_store   (op_is_store(op_in)),
        .acc_len_m1  (len_m1),
        .issue       (issue),
        .store_phase (store_phase),
        .commit_load (commit_load),
        .busy_o      (busy),
        .done_o      (done)
    );

    wlsu_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .start_addr (req_addr),
        .step       (issue),
        .addr_o     (mem_addr)
    );

    wlsu_shift #(.BYTE_W(BYTE_W), .NBYTES(FLOAT_BYTES)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (accept),
        .load_val (load_val),
        .shl_en   (issue && store_phase),
        .shin_en  (rd_pend_q),
        .byte_in  (mem_rdata),
        .byte_out (mem_wdata),
        .value    (sh_val)
    );

    assign mem_en = issue;
    assign mem_we = issue && store_phase;

    // Register write-back
    assign rf_we     = commit_load && (size_q != SZ_FLOAT);
    assign rf_fwe    = commit_load && (size_q == SZ_FLOAT);
    assign rf_wsel   = sel_q;
    assign rf_fwdata = sh_val;
    assign rf_wdata  = (size_q == SZ_BYTE)
                     ? {hold_q[WORD_W-1:BYTE_W], sh_val[BYTE_W-1:0]}
                     : sh_val[WORD_W-1:0];

endmodule

// File: rtl/wlsu_checker.sv
module wlsu_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rf_we,
    input logic              rf_fwe
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                             // R10
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);                                             // R10
    AST_ACCESS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> busy);                                            // R9
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && $past(mem_en)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R9
    AST_RF_WRITE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || rf_fwe) |-> done);                                 // R3
    AST_ONE_WRITE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && rf_fwe));                                         // R4

endmodule

bind wordmover_lsu wlsu_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .mem_en   (mem_en),
    .mem_addr (mem_addr),
    .rf_we    (rf_we),
    .rf_fwe   (rf_fwe)
);

// File: tb/wordmover_lsu_tb.sv
module wordmover_lsu_tb;

    localparam int ADDR_W = 8;
    localparam int MEMSZ  = 1 << ADDR_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [7:0]  req_addr = '0;
    logic [2:0]  req_sel = '0;
    logic        busy, done, mem_en, mem_we;
    logic [7:0]  mem_addr, mem_wdata, mem_rdata;
    logic [2:0]  rf_rsel, rf_wsel;
    logic [23:0] rf_rdata, rf_wdata;
    logic [47:0] rf_fdata, rf_fwdata;
    logic        rf_we, rf_fwe;

    always #2.5 clk = ~clk;   // 200 MHz

    wordmover_lsu u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_sel(req_sel), .busy(busy), .done(done),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rf_rsel(rf_rsel),
        .rf_rdata(rf_rdata), .rf_fdata(rf_fdata), .rf_we(rf_we),
        .rf_wsel(rf_wsel), .rf_wdata(rf_wdata), .rf_fwe(rf_fwe),
        .rf_fwdata(rf_fwdata)
    );

    // Environment: byte RAM and register file
    logic [7:0]  ram [MEMSZ];
    logic [23:0] regs [6];
    logic [47:0] freg;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEMSZ; i++) ram[i] <= 8'((i * 37 + 11) % 256);
            mem_rdata <= '0;
        end else if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata     <= ram[mem_addr];
        end
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs[0] <= 24'h123456; regs[1] <= 24'hA1B2C3; regs[2] <= 24'h0F0E0D;
            regs[3] <= 24'h445566; regs[4] <= 24'hCAFE01; regs[5] <= 24'h778899;
            freg    <= 48'h9876_5432_10FE;
        end else begin
            if (rf_we && rf_wsel < 3'd6) regs[rf_wsel] <= rf_wdata;
            if (rf_fwe) freg <= rf_fwdata;
        end
    end

    assign rf_rdata = (rf_rsel < 3'd6) ? regs[rf_rsel] : 24'h0;
    assign rf_fdata = freg;

    // Scoreboard
    typedef struct {
        logic [2:0]  op;
        logic [2:0]  sel;
        int          addr;
        int          nbytes;
        logic [47:0] exp;
        int          end_cyc;
        string       tag;
    } item_t;

    item_t queue[$];
    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nb(input logic [2:0] op);
        case (op)
            3'd0, 3'd4: return 3;
            3'd1, 3'd5: return 6;
            default:    return 1;
        endcase
    endfunction

    // Driver: one request, one cycle; pushes the expected item when it should be accepted
    task automatic drive(input logic [2:0] op, input logic [2:0] sel, input int addr,
                         input bit expect_acc, input string tag);
        item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        if (expect_acc) begin
            it.op = op; it.addr = addr; it.nbytes = nb(op); it.tag = tag;
            it.sel = (op == 3'd2 || op == 3'd6) ? 3'd0 : sel;
            it.exp = '0;
            if (op[2]) begin
                it.end_cyc = cyc + it.nbytes + 1;
                case (op)
                    3'd4:    it.exp = {24'h0, regs[sel]};
                    3'd5:    it.exp = freg;
                    default: it.exp = {40'h0, regs[0][7:0]};
                endcase
            end else begin
                it.end_cyc = cyc + it.nbytes + 2;
                for (int i = 0; i < it.nbytes; i++)
                    it.exp = {it.exp[39:0], ram[(addr + i) % MEMSZ]};
                if (op == 3'd2) it.exp = {24'h0, regs[0][23:8], it.exp[7:0]};
            end
            queue.push_back(it);
        end
        req_valid = 1'b1; req_op = op; req_sel = sel; req_addr = 8'(addr);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (queue.size() == 0) begin
                chk(1'b0, "R11 unexpected done", 48'h1, 48'h0);
            end else begin
                item_t it;
                logic [47:0] got;
                it = queue.pop_front();
                chk(cyc == it.end_cyc, {it.tag, " R10 latency"}, 48'(cyc), 48'(it.end_cyc));
                if (it.op[2]) begin
                    got = '0;
                    for (int i = 0; i < it.nbytes; i++)
                        got = {got[39:0], ram[(it.addr + i) % MEMSZ]};
                    chk(got == it.exp, {it.tag, " stored bytes"}, got, it.exp);
                end else if (it.op == 3'd1) begin
                    chk(rf_fwe && !rf_we && rf_fwdata == it.exp, {it.tag, " R4 float write"},
                        rf_fwdata, it.exp);
                end else begin
                    chk(rf_we && !rf_fwe && rf_wsel == it.sel && rf_wdata == it.exp[23:0],
                        {it.tag, " word/byte write"}, {21'h0, rf_wsel, rf_wdata},
                        {21'h0, it.sel, it.exp[23:0]});
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    logic [7:0] saved200;

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_en && !rf_we && !rf_fwe, "R1 reset quiet",
            {43'h0, busy, done, mem_en, rf_we, rf_fwe}, 48'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_en, "R1 after release", {45'h0, busy, done, mem_en}, 48'h0);
        saved200 = ram[200];

        drive(3'd0, 3'd3, 10,  1, "R3 load word B");
        drive(3'd0, 3'd1, 254, 1, "R3 R9 load word X wrap");
        drive(3'd1, 3'd0, 40,  1, "R4 load float");
        drive(3'd2, 3'd5, 77,  1, "R5 load byte keeps A upper");
        drive(3'd4, 3'd4, 120, 1, "R6 store word S");
        drive(3'd5, 3'd0, 252, 1, "R7 R9 store float wrap");
        drive(3'd6, 3'd2, 130, 1, "R8 store byte");
        // presented while busy: must be ignored
        req_valid = 1'b1; req_op = 3'd6; req_addr = 8'd200;
        @(negedge clk);
        req_valid = 1'b0;
        drive(3'd4, 3'd0, 60,  1, "R6 store word A");
        drive(3'd0, 3'd5, 60,  1, "R3 reload into T");
        drive(3'd3, 3'd0, 5,   0, "R2 op 3");
        chk(!busy, "R2 op 3 ignored", {47'h0, busy}, 48'h0);
        drive(3'd7, 3'd0, 5,   0, "R2 op 7");
        chk(!busy, "R2 op 7 ignored", {47'h0, busy}, 48'h0);
        drive(3'd0, 3'd6, 5,   0, "R2 bad selector");
        chk(!busy, "R2 selector 6 ignored", {47'h0, busy}, 48'h0);
        drive(3'd2, 3'd0, 131, 1, "R5 second byte load");

        repeat (20) @(negedge clk);
        chk(queue.size() == 0, "R10 all completions seen", 48'(queue.size()), 48'h0);
        chk(ram[200] == saved200, "R11 busy request ignored", {40'h0, ram[200]}, {40'h0, saved200});
        chk(ram[131] == 8'((131 * 37 + 11) % 256) && ram[129] == 8'((129 * 37 + 11) % 256),
            "R8 neighbours untouched", {32'h0, ram[129], ram[131]},
            {32'h0, 8'((129 * 37 + 11) % 256), 8'((131 * 37 + 11) % 256)});
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule